// File: doc/BRIEF.md
# I2C Status Flag Register

This block keeps the event and error flags of an I2C peripheral and applies the rules by which each flag is set and cleared. The bus engine sends it one-cycle event pulses. The register interface sends it one-cycle access strobes: status read, status write with its data, second-status read, data read, data write and control write. A peripheral-enable input empties every flag. The block drives the packed status word and one output per flag.

The block has three kinds of flag. Error flags are cleared when software writes a zero to their bit. Data flags are cleared directly by a data access or by a start or stop condition. Sequence flags are cleared in two steps: a status read that sees the flag already set arms a pending bit, and a later access of a given kind then clears the flag. Every flag is a register, so an event or access seen at a clock edge shows on the outputs right after that edge.

Top module: `i2c_status_flags`

## Requirements
- R1: The status word places the flags at fixed bits: 10 ack failure, 9 arbitration lost, 8 bus error, 7 transmit empty, 6 receive full, 4 stop seen, 3 10-bit header sent, 2 byte done, 1 address done. Bits 0, 5 and 11 and above read 0. Each per-flag output equals its bit.
- R2: An event pulse sets ack failure, arbitration lost or bus error. A status write clears each of these flags whose data bit is 0. A status write whose data bit is 1 leaves that flag unchanged.
- R3: Reset, or a low peripheral enable at a clock edge, makes every flag and every pending bit 0 after that edge.
- R4: An event pulse sets transmit empty. A data write or a start/stop condition clears it.
- R5: An event pulse sets receive full. A data read or a data write clears it.
- R6: The stop flag clears on a control write only if an earlier status read saw the stop flag set.
- R7: The 10-bit header flag clears on a data write only if an earlier status read saw it set.
- R8: The byte-done flag clears on a data read or data write only if an earlier status read saw it set. A start/stop condition clears it with no earlier read.
- R9: The address flag clears on a second-status read only if an earlier status read saw it set.
- R10: A status read arms a flag only if that flag was already 1 before the read. A clearing access consumes the arming, and a flag that drops to 0 loses its arming. A flag set after the read is therefore not cleared by the second access. A status read and a second access in the same cycle use the arming made before that cycle.
- R11: When a set event and a clear condition for the same flag fall in the same cycle, the flag is 1 afterwards.
- R12: A status write changes none of the flags at bits 7, 6, 4, 3, 2 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; low empties all flags |
| ev_ack_fail | input | 1 | Acknowledge failure event |
| ev_arb_lost | input | 1 | Arbitration lost event |
| ev_bus_err | input | 1 | Misplaced start/stop event |
| ev_tx_empty | input | 1 | Transmit data register emptied |
| ev_rx_full | input | 1 | Receive data register filled |
| ev_byte_done | input | 1 | Byte transfer finished |
| ev_stop | input | 1 | Stop condition seen as target |
| ev_hdr10 | input | 1 | First 10-bit address byte sent |
| ev_addr | input | 1 | Address sent or matched |
| ev_bus_cond | input | 1 | Start or stop condition on the bus |
| acc_rd_status | input | 1 | Status word read strobe |
| acc_wr_status | input | 1 | Status word write strobe |
| acc_wdata | input | WORD_W | Status write data |
| acc_rd_status2 | input | 1 | Second status register read strobe |
| acc_rd_data | input | 1 | Data register read strobe |
| acc_wr_data | input | 1 | Data register write strobe |
| acc_wr_ctrl | input | 1 | Control register write strobe |
| status_word | output | WORD_W | Packed flags |
| fl_ack_fail | output | 1 | Ack failure flag |
| fl_arb_lost | output | 1 | Arbitration lost flag |
| fl_bus_err | output | 1 | Bus error flag |
| fl_tx_empty | output | 1 | Transmit empty flag |
| fl_rx_full | output | 1 | Receive full flag |
| fl_stop | output | 1 | Stop seen flag |
| fl_hdr10 | output | 1 | 10-bit header sent flag |
| fl_byte_done | output | 1 | Byte done flag |
| fl_addr | output | 1 | Address done flag |

## Verification
The collision that matters is a set event for a flag arriving in the same cycle as that flag's clearing access. Examples are an ack-failure pulse during a zero-writing status write, and a stop event during the control write that follows an armed status read. The random stimulus raises events and access strobes independently each cycle, so such collisions occur often. Directed cases also force them on purpose. After each edge the bench compares every flag with a model built from R10 and R11. Set must win. Arming must depend only on the flag's value before the status read.

// File: rtl/i2c_sf_pkg.sv
package i2c_sf_pkg;
  localparam int POS_ACKERR   = 10;
  localparam int POS_ARBLOST  = 9;
  localparam int POS_BUSERR   = 8;
  localparam int POS_TXEMPTY  = 7;
  localparam int POS_RXFULL   = 6;
  localparam int POS_STOP     = 4;
  localparam int POS_HDR10    = 3;
  localparam int POS_BYTEDONE = 2;
  localparam int POS_ADDR     = 1;
  localparam int N_ERR        = 3;
  localparam int N_SEQ        = 4;
  localparam int MIN_WORD_W   = POS_ACKERR + 1;
endpackage

// File: rtl/i2c_sf_flag.sv
// Plain set/clear flag, set has priority, enable low empties it.
module i2c_sf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic d, ld;

  always_comb begin
    if (!en)      d = 1'b0;
    else if (set) d = 1'b1;
    else if (clr) d = 1'b0;
    else          d = q;
    ld = d ^ q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/i2c_sf_seqflag.sv
// Flag cleared by a status read that saw it set, followed by a second access.
module i2c_sf_seqflag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set,
  input  logic arm,
  input  logic consume,
  input  logic hw_clr,
  output logic q
);
  logic pend_q, d, pend_d, take, ld, pend_ld;

  always_comb begin
    take = pend_q & consume;
    if (!en)                 d = 1'b0;
    else if (set)            d = 1'b1;
    else if (take || hw_clr) d = 1'b0;
    else                     d = q;

    if (!en || !d)           pend_d = 1'b0;
    else if (arm && q)       pend_d = 1'b1;
    else if (take)           pend_d = 1'b0;
    else                     pend_d = pend_q;

    ld      = d ^ q;
    pend_ld = pend_d ^ pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (ld) q <= d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_ld) pend_q <= pend_d;
  end
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periph_en,
  input  logic              ev_ack_fail,
  input  logic              ev_arb_lost,
  input  logic              ev_bus_err,
  input  logic              ev_tx_empty,
  input  logic              ev_rx_full,
  input  logic              ev_byte_done,
  input  logic              ev_stop,
  input  logic              ev_hdr10,
  input  logic              ev_addr,
  input  logic              ev_bus_cond,
  input  logic              acc_rd_status,
  input  logic              acc_wr_status,
  input  logic [WORD_W-1:0] acc_wdata,
  input  logic              acc_rd_status2,
  input  logic              acc_rd_data,
  input  logic              acc_wr_data,
  input  logic              acc_wr_ctrl,
  output logic [WORD_W-1:0] status_word,
  output logic              fl_ack_fail,
  output logic              fl_arb_lost,
  output logic              fl_bus_err,
  output logic              fl_tx_empty,
  output logic              fl_rx_full,
  output logic              fl_stop,
  output logic              fl_hdr10,
  output logic              fl_byte_done,
  output logic              fl_addr
);
  import i2c_sf_pkg::*;

  localparam int ERR_N = N_ERR;
  localparam int SEQ_N = N_SEQ;

  logic [ERR_N-1:0] err_set, err_q;
  logic [SEQ_N-1:0] seq_set, seq_cons, seq_hw, seq_q;

  // error flags: index 0 ack, 1 arbitration, 2 bus error
  assign err_set = {ev_bus_err, ev_arb_lost, ev_ack_fail};

  for (genvar g = 0; g < ERR_N; g++) begin : g_err
    localparam int P = (g == 0) ? POS_ACKERR : (g == 1) ? POS_ARBLOST : POS_BUSERR;
    i2c_sf_flag u_flag (
      .clk (clk),
      .rst_n (rst_n),
      .en  (periph_en),
      .set (err_set[g]),
      .clr (acc_wr_status & ~acc_wdata[P]),
      .q   (err_q[g])
    );
  end

  i2c_sf_flag u_txe (
    .clk (clk), .rst_n (rst_n), .en (periph_en),
    .set (ev_tx_empty),
    .clr (acc_wr_data | ev_bus_cond),
    .q   (fl_tx_empty)
  );

  i2c_sf_flag u_rxf (
    .clk (clk), .rst_n (rst_n), .en (periph_en),
    .set (ev_rx_full),
    .clr (acc_rd_data | acc_wr_data),
    .q   (fl_rx_full)
  );

  // sequence flags: index 0 stop, 1 header, 2 byte done, 3 address
  assign seq_set  = {ev_addr, ev_byte_done, ev_hdr10, ev_stop};
  assign seq_cons = {acc_rd_status2, acc_rd_data | acc_wr_data, acc_wr_data, acc_wr_ctrl};
  assign seq_hw   = {1'b0, ev_bus_cond, 1'b0, 1'b0};

  for (genvar g = 0; g < SEQ_N; g++) begin : g_seq
    i2c_sf_seqflag u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (periph_en),
      .set     (seq_set[g]),
      .arm     (acc_rd_status),
      .consume (seq_cons[g]),
      .hw_clr  (seq_hw[g]),
      .q       (seq_q[g])
    );
  end

  assign fl_ack_fail  = err_q[0];
  assign fl_arb_lost  = err_q[1];
  assign fl_bus_err   = err_q[2];
  assign fl_stop      = seq_q[0];
  assign fl_hdr10     = seq_q[1];
  assign fl_byte_done = seq_q[2];
  assign fl_addr      = seq_q[3];

  always_comb begin
    status_word               = '0;
    status_word[POS_ACKERR]   = fl_ack_fail;
    status_word[POS_ARBLOST]  = fl_arb_lost;
    status_word[POS_BUSERR]   = fl_bus_err;
    status_word[POS_TXEMPTY]  = fl_tx_empty;
    status_word[POS_RXFULL]   = fl_rx_full;
    status_word[POS_STOP]     = fl_stop;
    status_word[POS_HDR10]    = fl_hdr10;
    status_word[POS_BYTEDONE] = fl_byte_done;
    status_word[POS_ADDR]     = fl_addr;
  end
endmodule

// File: rtl/i2c_sf_checker.sv
module i2c_sf_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              periph_en,
  input logic              ev_ack_fail,
  input logic              ev_arb_lost,
  input logic              ev_bus_err,
  input logic              ev_tx_empty,
  input logic              ev_rx_full,
  input logic              ev_byte_done,
  input logic              ev_stop,
  input logic              ev_bus_cond,
  input logic              acc_wr_status,
  input logic [WORD_W-1:0] acc_wdata,
  input logic              acc_rd_data,
  input logic              acc_wr_data,
  input logic              acc_wr_ctrl,
  input logic [WORD_W-1:0] status_word,
  input logic              fl_ack_fail,
  input logic              fl_arb_lost,
  input logic              fl_bus_err,
  input logic              fl_tx_empty,
  input logic              fl_rx_full,
  input logic              fl_stop,
  input logic              fl_byte_done
);
  assert_disable_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |=> status_word == '0);

  assert_zero_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en && acc_wr_status && !acc_wdata[10] && !ev_ack_fail |=> !fl_ack_fail);

  assert_one_write_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en && acc_wr_status && acc_wdata[9] && fl_arb_lost |=> fl_arb_lost);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en && ev_bus_err |=> fl_bus_err);

  assert_txe_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en && (acc_wr_data || ev_bus_cond) && !ev_tx_empty |=> !fl_tx_empty);

  assert_rxf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en && (acc_rd_data || acc_wr_data) && !ev_rx_full |=> !fl_rx_full);

  assert_stop_only_by_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_stop && !ev_stop |=> !fl_stop);

  assert_bytedone_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en && ev_bus_cond && !ev_byte_done |=> !fl_byte_done);

  assert_status_write_ro_R12: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en && acc_wr_status && !acc_wr_ctrl && fl_stop |=> fl_stop);
endmodule

bind i2c_status_flags i2c_sf_checker #(.WORD_W(WORD_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .periph_en (periph_en),
  .ev_ack_fail (ev_ack_fail), .ev_arb_lost (ev_arb_lost), .ev_bus_err (ev_bus_err),
  .ev_tx_empty (ev_tx_empty), .ev_rx_full (ev_rx_full), .ev_byte_done (ev_byte_done),
  .ev_stop (ev_stop), .ev_bus_cond (ev_bus_cond),
  .acc_wr_status (acc_wr_status), .acc_wdata (acc_wdata),
  .acc_rd_data (acc_rd_data), .acc_wr_data (acc_wr_data), .acc_wr_ctrl (acc_wr_ctrl),
  .status_word (status_word),
  .fl_ack_fail (fl_ack_fail), .fl_arb_lost (fl_arb_lost), .fl_bus_err (fl_bus_err),
  .fl_tx_empty (fl_tx_empty), .fl_rx_full (fl_rx_full), .fl_stop (fl_stop),
  .fl_byte_done (fl_byte_done)
);

// File: tb/i2c_status_flags_test.sv
`timescale 1ns/1ps
module i2c_status_flags_test;
  typedef struct packed {
    logic en;
    logic ack, arb, berr, txe, rxf, bdone, stop, hdr, addr, cond;
    logic rs, ws, rs2, rd, wd, wc;
    logic [15:0] wdata;
  } stim_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  stim_t s;
  logic [15:0] status_word;
  logic fl_ack_fail, fl_arb_lost, fl_bus_err, fl_tx_empty, fl_rx_full;
  logic fl_stop, fl_hdr10, fl_byte_done, fl_addr;

  int vectors = 0;
  int miscompares = 0;
  logic [15:0] m_flag = '0;
  logic [15:0] m_pend = '0;

  always #2 clk = ~clk;

  i2c_status_flags #(.WORD_W(16)) uut (
    .clk (clk), .rst_n (rst_n), .periph_en (s.en),
    .ev_ack_fail (s.ack), .ev_arb_lost (s.arb), .ev_bus_err (s.berr),
    .ev_tx_empty (s.txe), .ev_rx_full (s.rxf), .ev_byte_done (s.bdone),
    .ev_stop (s.stop), .ev_hdr10 (s.hdr), .ev_addr (s.addr), .ev_bus_cond (s.cond),
    .acc_rd_status (s.rs), .acc_wr_status (s.ws), .acc_wdata (s.wdata),
    .acc_rd_status2 (s.rs2), .acc_rd_data (s.rd), .acc_wr_data (s.wd),
    .acc_wr_ctrl (s.wc),
    .status_word (status_word),
    .fl_ack_fail (fl_ack_fail), .fl_arb_lost (fl_arb_lost), .fl_bus_err (fl_bus_err),
    .fl_tx_empty (fl_tx_empty), .fl_rx_full (fl_rx_full), .fl_stop (fl_stop),
    .fl_hdr10 (fl_hdr10), .fl_byte_done (fl_byte_done), .fl_addr (fl_addr)
  );

  function automatic string req_of(int b);
    case (b)
      10, 9, 8: return "R2/R11";
      7:        return "R4/R11";
      6:        return "R5/R11";
      4:        return "R6/R10/R12";
      3:        return "R7/R10";
      2:        return "R8/R10";
      1:        return "R9/R10";
      default:  return "R1";
    endcase
  endfunction

  function automatic stim_t idle();
    stim_t t = '0;
    t.en = 1'b1;
    t.wdata = 16'hFFFF;
    return t;
  endfunction

  // plain flag rule used by R2, R4, R5, R11
  function automatic logic plain_next(logic q, logic en, logic set, logic clr);
    if (!en) return 1'b0;
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return q;
  endfunction

  // two-step rule from R6..R11
  task automatic seq_model(int b, logic set, logic cons, logic hw);
    logic q = m_flag[b];
    logic p = m_pend[b];
    logic nq, np;
    nq = plain_next(q, s.en, set, (p & cons) | hw);
    if (!s.en || !nq)       np = 1'b0;
    else if (s.rs && q)     np = 1'b1;
    else if (p && cons)     np = 1'b0;
    else                    np = p;
    m_flag[b] = nq;
    m_pend[b] = np;
  endtask

  task automatic model_step();
    m_flag[10] = plain_next(m_flag[10], s.en, s.ack,  s.ws & ~s.wdata[10]);
    m_flag[9]  = plain_next(m_flag[9],  s.en, s.arb,  s.ws & ~s.wdata[9]);
    m_flag[8]  = plain_next(m_flag[8],  s.en, s.berr, s.ws & ~s.wdata[8]);
    m_flag[7]  = plain_next(m_flag[7],  s.en, s.txe,  s.wd | s.cond);
    m_flag[6]  = plain_next(m_flag[6],  s.en, s.rxf,  s.rd | s.wd);
    seq_model(4, s.stop,  s.wc,         1'b0);
    seq_model(3, s.hdr,   s.wd,         1'b0);
    seq_model(2, s.bdone, s.rd | s.wd,  s.cond);
    seq_model(1, s.addr,  s.rs2,        1'b0);
  endtask

  task automatic compare(string tag);
    logic [15:0] fl;
    logic bad = 1'b0;
    vectors++;
    for (int b = 0; b < 16; b++) begin
      if (status_word[b] !== m_flag[b]) begin
        bad = 1'b1;
        $display("FAIL %s %s bit %0d: actual %0b expected %0b", tag, req_of(b), b,
                 status_word[b], m_flag[b]);
      end
    end
    fl = '0;
    fl[10] = fl_ack_fail; fl[9] = fl_arb_lost; fl[8] = fl_bus_err;
    fl[7] = fl_tx_empty; fl[6] = fl_rx_full; fl[4] = fl_stop;
    fl[3] = fl_hdr10; fl[2] = fl_byte_done; fl[1] = fl_addr;
    if (fl !== m_flag) begin
      bad = 1'b1;
      $display("FAIL %s R1 flag outputs: actual %h expected %h", tag, fl, m_flag);
    end
    if (bad) miscompares++;
  endtask

  task automatic apply(stim_t t, string tag);
    @(negedge clk);
    s = t;
    @(posedge clk);
    #1;
    model_step();
    compare(tag);
  endtask

  initial begin
    #(400000 * 4);
    $display("FAIL watchdog R3: actual running expected finished");
    miscompares++;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    stim_t t;
    void'($urandom(32'h1C5F));
    s = idle();
    s.ack = 1'b1; s.stop = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    compare("reset R3");
    @(negedge clk);
    rst_n = 1'b1;
    s = idle();

    // R2: write of ones keeps, write of zero clears, set wins R11
    t = idle(); t.ack = 1'b1; t.arb = 1'b1; t.berr = 1'b1; apply(t, "R2 set");
    t = idle(); t.ws = 1'b1; apply(t, "R2 write ones");
    t = idle(); t.ws = 1'b1; t.wdata = 16'h0000; t.ack = 1'b1; apply(t, "R11 set vs zero write");
    t = idle(); t.ws = 1'b1; t.wdata = 16'hFBFF; apply(t, "R2 clear ack only");
    t = idle(); t.ws = 1'b1; t.wdata = 16'h0000; apply(t, "R2 clear all");
    // R6 and R10: read while clear does not arm
    t = idle(); t.rs = 1'b1; apply(t, "R10 read while clear");
    t = idle(); t.stop = 1'b1; t.addr = 1'b1; t.hdr = 1'b1; t.bdone = 1'b1; apply(t, "R6 set");
    t = idle(); t.wc = 1'b1; t.rs2 = 1'b1; t.wd = 1'b1; apply(t, "R10 no arm");
    t = idle(); t.ws = 1'b1; t.wdata = 16'h0000; apply(t, "R12 status write");
    t = idle(); t.rs = 1'b1; apply(t, "R10 arm");
    t = idle(); t.wc = 1'b1; t.stop = 1'b1; apply(t, "R11 stop set vs clear");
    t = idle(); t.wc = 1'b1; apply(t, "R10 consumed");
    t = idle(); t.rs2 = 1'b1; apply(t, "R9 clear");
    t = idle(); t.wd = 1'b1; apply(t, "R7 R8 clear");
    // R4 R5 R8 start/stop condition
    t = idle(); t.txe = 1'b1; t.rxf = 1'b1; t.bdone = 1'b1; apply(t, "R4 R5 set");
    t = idle(); t.cond = 1'b1; apply(t, "R4 R8 condition");
    t = idle(); t.rd = 1'b1; apply(t, "R5 data read");
    // R3 disable
    t = idle(); t.ack = 1'b1; t.stop = 1'b1; t.txe = 1'b1; apply(t, "R3 prep");
    t = idle(); t.en = 1'b0; t.ack = 1'b1; apply(t, "R3 disable");

    for (int i = 0; i < 4000; i++) begin
      t = '0;
      t.en    = ($urandom % 40) != 0;
      t.ack   = ($urandom % 7) == 0;
      t.arb   = ($urandom % 7) == 0;
      t.berr  = ($urandom % 7) == 0;
      t.txe   = ($urandom % 5) == 0;
      t.rxf   = ($urandom % 5) == 0;
      t.bdone = ($urandom % 5) == 0;
      t.stop  = ($urandom % 6) == 0;
      t.hdr   = ($urandom % 6) == 0;
      t.addr  = ($urandom % 6) == 0;
      t.cond  = ($urandom % 9) == 0;
      t.rs    = ($urandom % 3) == 0;
      t.ws    = ($urandom % 5) == 0;
      t.rs2   = ($urandom % 4) == 0;
      t.rd    = ($urandom % 4) == 0;
      t.wd    = ($urandom % 4) == 0;
      t.wc    = ($urandom % 4) == 0;
      t.wdata = 16'($urandom);
      apply(t, "random R1-mix");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule